// File: doc/BRIEF.md
# Uncorrectable and Correctable Error Status Register Block

This block keeps the error status seen by a memory-attached device and hands it to host software. It holds status, mask and severity for uncorrectable errors, status and mask for correctable errors, and a capability/control word. That word carries a pointer to the oldest pending uncorrectable error. A header log holds the header words that the injector supplied for that error.

Errors arrive on an injection port. Uncorrectable errors are held in order in a small pending queue. Several can be injected back to back, one per cycle, and each brings its own header words. The status register shows the union of all queued errors. Software retires the oldest error by writing exactly the status bit that the pointer names. The pointer and the header log then move to the next queued entry. Correctable errors are injected one per cycle and set a plain write-1-to-clear status bit. Any accepted injection whose bit is unmasked produces a one-cycle interrupt-request pulse toward the host error-reporting path.

Register word addresses are fixed:

| Address | Register |
|---|---|
| 0 | uncorrectable status |
| 1 | uncorrectable mask |
| 2 | uncorrectable severity |
| 3 | correctable status |
| 4 | correctable mask |
| 5 | capability/control |
| 16 to 31 | header log words 0 to 15 |

Every other address reads zero.

Top module: `ras_err_regs`

## Requirements
- R1: After reset, the registers read as follows: uncorrectable status 0, uncorrectable mask 0x1cfff, uncorrectable severity 0x1cfff, correctable status 0, correctable mask 0x7f, capability/control 0x200. Every header log word reads 0, irq_o is 0 and q_overflow_o is 0.
- R2: Writes to the uncorrectable mask and severity keep only bits 0x1cfff. Writes to the correctable mask keep only bits 0x7f. The capability/control word is read-only. Reserved bits always read zero.
- R3: An uncorrectable injection is legal when its kind is a status bit index in {0..11, 14, 15, 16}. A legal injection is queued and its status bit reads set from the next cycle. A kind of 12, 13 or above 16 is ignored.
- R4: Capability/control bits 5:0 give the kind of the oldest queued uncorrectable error, and bit 9 reads 1. The header log shows that error's header. With an empty queue, the pointer reads 0 and the header log reads zero.
- R5: An injection carries a word count n. Header words at index n and above read zero, whatever was driven on them.
- R6: Writing to uncorrectable status the single bit that the pointer names removes the oldest entry. In the next cycle, status is the union of the remaining entries, and the pointer and header log belong to the next entry.
- R7: While the queue is non-empty, any other write to uncorrectable status has no effect. This covers a different single bit, and also several bits that include the pointed bit.
- R8: The queue holds QDEPTH (8) entries. A legal injection into a full queue is dropped, and it sets q_overflow_o, which stays set until reset.
- R9: A correctable injection of kind k in 0..6 sets status bit k, and kind 7 is ignored. Status bits are write-1-to-clear. An injection wins over a clear of the same bit in the same cycle.
- R10: irq_o is high for exactly the cycle after each accepted injection whose status bit is unmasked. It stays low for masked, illegal or dropped injections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| unc_inj_valid_i | input | 1 | Uncorrectable injection strobe |
| unc_inj_kind_i | input | 5 | Uncorrectable status bit index |
| unc_inj_nwords_i | input | 5 | Number of meaningful header words |
| unc_inj_hdr_i | input | 512 | Header words, word i in bits 32i+31:32i |
| cor_inj_valid_i | input | 1 | Correctable injection strobe |
| cor_inj_kind_i | input | 3 | Correctable status bit index |
| irq_o | output | 1 | Interrupt-request pulse |
| q_overflow_o | output | 1 | Sticky queue-overflow flag |

## Verification
The bench targets retirement of the oldest error. A design that pops on any write, or on a multi-bit write that contains the pointed bit, would move the pointer or lose status bits early. A design that forgets to reload from the next entry would leave a stale header or a stale pointer. Word-count clipping, the ninth injection into a full queue, and illegal kinds are all checked. A design that got these wrong would show leftover header data, silently overwrite the oldest entry, or raise status and interrupt for reserved bits. Interrupt gating by mask and the same-cycle correctable set-versus-clear race are also compared cycle by cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int REG_AW     = 5;
    localparam int DW         = 32;
    localparam int UNC_W      = 17;
    localparam int COR_W      = 7;
    localparam int KIND_W     = 5;
    localparam int COR_KIND_W = 3;
    localparam int PTR_FIELD  = 6;
    localparam int HDR_BASE   = 16;

    localparam logic [DW-1:0] UNC_WMASK = 32'h0001_cfff;
    localparam logic [DW-1:0] COR_WMASK = 32'h0000_007f;
    localparam logic [DW-1:0] CAP_FIXED = 32'h0000_0200;

    localparam logic [REG_AW-1:0] A_UNC_STAT = 5'd0;
    localparam logic [REG_AW-1:0] A_UNC_MASK = 5'd1;
    localparam logic [REG_AW-1:0] A_UNC_SEV  = 5'd2;
    localparam logic [REG_AW-1:0] A_COR_STAT = 5'd3;
    localparam logic [REG_AW-1:0] A_COR_MASK = 5'd4;
    localparam logic [REG_AW-1:0] A_CAP      = 5'd5;

    // legal uncorrectable kinds: bits 0..11 and 14..16
    function automatic logic unc_kind_ok(input logic [KIND_W-1:0] k);
        return (k <= 5'd16) && (k != 5'd12) && (k != 5'd13);
    endfunction

    function automatic logic [UNC_W-1:0] unc_onehot(input logic [KIND_W-1:0] k);
        return UNC_W'(1) << k;
    endfunction

    function automatic logic [COR_W-1:0] cor_onehot(input logic [COR_KIND_W-1:0] k);
        return COR_W'(1) << k;
    endfunction

endpackage

// File: rtl/ras_unc_queue.sv
module ras_unc_queue
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int HDR_W = 512,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              push_i,
    input  logic [KIND_W-1:0] push_kind_i,
    input  logic [HDR_W-1:0]  push_hdr_i,
    input  logic              pop_i,
    output logic [KIND_W-1:0] head_kind_o,
    output logic [HDR_W-1:0]  head_hdr_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [UNC_W-1:0]  kinds_or_o
);

    typedef struct packed {
        logic [DEPTH-1:0][HDR_W-1:0]  hdr;
        logic [DEPTH-1:0][KIND_W-1:0] kind;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } q_state_t;

    q_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i && (st_q.cnt < CNT_W'(DEPTH))) begin
            st_d.hdr[st_q.wr]  = push_hdr_i;
            st_d.kind[st_q.wr] = push_kind_i;
            st_d.wr            = st_q.wr + PTR_W'(1);
        end
        if (pop_i && (st_q.cnt != '0)) begin
            st_d.rd = st_q.rd + PTR_W'(1);
        end
        st_d.cnt = st_q.cnt
                 + CNT_W'(push_i && (st_q.cnt < CNT_W'(DEPTH)))
                 - CNT_W'(pop_i && (st_q.cnt != '0));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // union of all pending kinds
    always_comb begin
        kinds_or_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [PTR_W-1:0] idx;
            idx = st_q.rd + PTR_W'(i);
            if (CNT_W'(i) < st_q.cnt) kinds_or_o = kinds_or_o | unc_onehot(st_q.kind[idx]);
        end
    end

    assign empty_o     = (st_q.cnt == '0);
    assign full_o      = (st_q.cnt == CNT_W'(DEPTH));
    assign head_kind_o = empty_o ? '0 : st_q.kind[st_q.rd];
    assign head_hdr_o  = empty_o ? '0 : st_q.hdr[st_q.rd];

endmodule

// File: rtl/ras_cor_status.sv
module ras_cor_status
    import ras_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_stat_i,
    input  logic                  wr_mask_i,
    input  logic [COR_W-1:0]      wdata_i,
    input  logic                  inj_i,
    input  logic [COR_KIND_W-1:0] inj_kind_i,
    output logic [COR_W-1:0]      stat_o,
    output logic [COR_W-1:0]      mask_o
);

    typedef struct packed {
        logic [COR_W-1:0] stat;
        logic [COR_W-1:0] mask;
    } cor_state_t;

    cor_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat_i) st_d.stat = st_q.stat & ~wdata_i;
        if (wr_mask_i) st_d.mask = wdata_i;
        // set wins over a same-cycle clear
        if (inj_i)     st_d.stat = st_d.stat | cor_onehot(inj_kind_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.stat <= '0;
            st_q.mask <= COR_WMASK[COR_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;

endmodule

// File: rtl/ras_err_regs.sv
module ras_err_regs
    import ras_pkg::*;
#(
    parameter int QDEPTH    = 8,
    parameter int HDR_WORDS = 16,
    localparam int HDR_W    = HDR_WORDS * DW,
    localparam int NW_W     = $clog2(HDR_WORDS + 1)
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  reg_we_i,
    input  logic [REG_AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]         reg_wdata_i,
    output logic [DW-1:0]         reg_rdata_o,
    input  logic                  unc_inj_valid_i,
    input  logic [KIND_W-1:0]     unc_inj_kind_i,
    input  logic [NW_W-1:0]       unc_inj_nwords_i,
    input  logic [HDR_W-1:0]      unc_inj_hdr_i,
    input  logic                  cor_inj_valid_i,
    input  logic [COR_KIND_W-1:0] cor_inj_kind_i,
    output logic                  irq_o,
    output logic                  q_overflow_o
);

    typedef struct packed {
        logic [UNC_W-1:0] unc_mask;
        logic [UNC_W-1:0] unc_sev;
        logic             ovf;
        logic             irq;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [HDR_W-1:0]  hdr_clip;
    logic [KIND_W-1:0] head_kind;
    logic [HDR_W-1:0]  head_hdr;
    logic              q_empty, q_full;
    logic [UNC_W-1:0]  unc_stat;
    logic [COR_W-1:0]  cor_stat, cor_mask;
    logic              unc_legal, unc_push, unc_drop, unc_pop, cor_hit;

    // zero header words beyond the supplied count
    for (genvar w = 0; w < HDR_WORDS; w++) begin : g_clip
        assign hdr_clip[w*DW +: DW] = (NW_W'(w) < unc_inj_nwords_i) ? unc_inj_hdr_i[w*DW +: DW] : '0;
    end

    assign unc_legal = unc_inj_valid_i && unc_kind_ok(unc_inj_kind_i);
    assign unc_push  = unc_legal && !q_full;
    assign unc_drop  = unc_legal && q_full;
    assign unc_pop   = reg_we_i && (reg_addr_i == A_UNC_STAT) && !q_empty
                    && (reg_wdata_i == DW'(unc_onehot(head_kind)));
    assign cor_hit   = cor_inj_valid_i && (cor_inj_kind_i != 3'd7);

    ras_unc_queue #(
        .DEPTH (QDEPTH),
        .HDR_W (HDR_W)
    ) u_queue (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (unc_push),
        .push_kind_i (unc_inj_kind_i),
        .push_hdr_i  (hdr_clip),
        .pop_i       (unc_pop),
        .head_kind_o (head_kind),
        .head_hdr_o  (head_hdr),
        .empty_o     (q_empty),
        .full_o      (q_full),
        .kinds_or_o  (unc_stat)
    );

    ras_cor_status u_cor (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_stat_i  (reg_we_i && (reg_addr_i == A_COR_STAT)),
        .wr_mask_i  (reg_we_i && (reg_addr_i == A_COR_MASK)),
        .wdata_i    (reg_wdata_i[COR_W-1:0]),
        .inj_i      (cor_hit),
        .inj_kind_i (cor_inj_kind_i),
        .stat_o     (cor_stat),
        .mask_o     (cor_mask)
    );

    always_comb begin
        st_d = st_q;
        if (reg_we_i && (reg_addr_i == A_UNC_MASK)) st_d.unc_mask = reg_wdata_i[UNC_W-1:0] & UNC_WMASK[UNC_W-1:0];
        if (reg_we_i && (reg_addr_i == A_UNC_SEV))  st_d.unc_sev  = reg_wdata_i[UNC_W-1:0] & UNC_WMASK[UNC_W-1:0];
        if (unc_drop) st_d.ovf = 1'b1;
        st_d.irq = (unc_push && !st_q.unc_mask[unc_inj_kind_i])
                || (cor_hit && !cor_mask[cor_inj_kind_i]);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.unc_mask <= UNC_WMASK[UNC_W-1:0];
            st_q.unc_sev  <= UNC_WMASK[UNC_W-1:0];
            st_q.ovf      <= 1'b0;
            st_q.irq      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_UNC_STAT: reg_rdata_o = DW'(unc_stat);
            A_UNC_MASK: reg_rdata_o = DW'(st_q.unc_mask);
            A_UNC_SEV:  reg_rdata_o = DW'(st_q.unc_sev);
            A_COR_STAT: reg_rdata_o = DW'(cor_stat);
            A_COR_MASK: reg_rdata_o = DW'(cor_mask);
            A_CAP:      reg_rdata_o = CAP_FIXED | DW'(PTR_FIELD'(head_kind));
            default: begin
                for (int w = 0; w < HDR_WORDS; w++) begin
                    if (reg_addr_i == REG_AW'(HDR_BASE + w)) reg_rdata_o = head_hdr[w*DW +: DW];
                end
            end
        endcase
    end

    assign irq_o        = st_q.irq;
    assign q_overflow_o = st_q.ovf;

endmodule

// File: rtl/ras_err_regs_chk.sv
module ras_err_regs_chk
    import ras_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [REG_AW-1:0]     reg_addr_i,
    input logic [DW-1:0]         reg_rdata_o,
    input logic                  unc_inj_valid_i,
    input logic [KIND_W-1:0]     unc_inj_kind_i,
    input logic                  cor_inj_valid_i,
    input logic                  irq_o,
    input logic                  q_overflow_o
);

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(unc_inj_valid_i || cor_inj_valid_i)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_overflow_o |=> q_overflow_o); // R8

    AST_UNC_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i <= A_UNC_SEV) |-> ((reg_rdata_o & ~UNC_WMASK) == '0)); // R2

    AST_COR_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((reg_addr_i == A_COR_STAT) || (reg_addr_i == A_COR_MASK)) |-> (reg_rdata_o[DW-1:COR_W] == '0)); // R9

    AST_PTR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == A_CAP) |-> ((reg_rdata_o[DW-1:PTR_FIELD] == 26'h8)
                                   && unc_kind_ok(reg_rdata_o[KIND_W-1:0])
                                   && !reg_rdata_o[KIND_W])); // R4

    AST_BAD_KIND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (unc_inj_valid_i && !unc_kind_ok(unc_inj_kind_i) && !cor_inj_valid_i) |=> !irq_o); // R3

endmodule

bind ras_err_regs ras_err_regs_chk chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_addr_i      (reg_addr_i),
    .reg_rdata_o     (reg_rdata_o),
    .unc_inj_valid_i (unc_inj_valid_i),
    .unc_inj_kind_i  (unc_inj_kind_i),
    .cor_inj_valid_i (cor_inj_valid_i),
    .irq_o           (irq_o),
    .q_overflow_o    (q_overflow_o)
);

// File: tb/ras_err_regs_tb_top.sv
`timescale 1ns/1ps
module ras_err_regs_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         reg_we = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         unc_v = 1'b0;
    logic [4:0]   unc_k = '0;
    logic [4:0]   unc_n = '0;
    logic [511:0] unc_h = '0;
    logic         cor_v = 1'b0;
    logic [2:0]   cor_k = '0;
    logic         irq, ovf;

    always #2.5 clk = ~clk;

    ras_err_regs dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .reg_we_i         (reg_we),
        .reg_addr_i       (reg_addr),
        .reg_wdata_i      (reg_wdata),
        .reg_rdata_o      (reg_rdata),
        .unc_inj_valid_i  (unc_v),
        .unc_inj_kind_i   (unc_k),
        .unc_inj_nwords_i (unc_n),
        .unc_inj_hdr_i    (unc_h),
        .cor_inj_valid_i  (cor_v),
        .cor_inj_kind_i   (cor_k),
        .irq_o            (irq),
        .q_overflow_o     (ovf)
    );

    typedef struct {
        int          sel;   // 0 rdata, 1 irq, 2 overflow
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // monitor: compares after each edge has settled
    initial forever begin
        @(posedge clk);
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                0:       act = reg_rdata;
                1:       act = {31'b0, irq};
                default: act = {31'b0, ovf};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
            end
        end
    end

    function automatic logic [511:0] mk_hdr(input logic [31:0] base);
        logic [511:0] h;
        for (int i = 0; i < 16; i++) h[i*32 +: 32] = base + 32'(i);
        return h;
    endfunction

    task automatic go_idle();
        reg_we = 1'b0; unc_v = 1'b0; cor_v = 1'b0;
    endtask

    task automatic push_exp(input int sel, input logic [31:0] exp, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_reg(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); go_idle();
        reg_addr = a;
        push_exp(0, exp, tag);
    endtask

    task automatic chk_ovf(input logic exp, input string tag);
        @(negedge clk); go_idle();
        push_exp(2, {31'b0, exp}, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); go_idle();
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        push_exp(1, 32'd0, "R10 no irq on write");
    endtask

    task automatic inj_unc(input logic [4:0] k, input logic [4:0] n, input logic [31:0] base,
                           input logic exp_irq, input string tag);
        @(negedge clk); go_idle();
        unc_v = 1'b1; unc_k = k; unc_n = n; unc_h = mk_hdr(base);
        push_exp(1, {31'b0, exp_irq}, tag);
    endtask

    task automatic inj_cor(input logic [2:0] k, input logic do_clr, input logic [31:0] clr,
                           input logic exp_irq, input string tag);
        @(negedge clk); go_idle();
        cor_v = 1'b1; cor_k = k;
        if (do_clr) begin reg_we = 1'b1; reg_addr = 5'd3; reg_wdata = clr; end
        push_exp(1, {31'b0, exp_irq}, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all-R actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk_reg(5'd0, 32'h0, "R1 unc status");
        chk_reg(5'd1, 32'h1cfff, "R1 unc mask");
        chk_reg(5'd2, 32'h1cfff, "R1 unc sev");
        chk_reg(5'd3, 32'h0, "R1 cor status");
        chk_reg(5'd4, 32'h7f, "R1 cor mask");
        chk_reg(5'd5, 32'h200, "R1 cap");
        chk_reg(5'd16, 32'h0, "R1 hdr0");
        chk_ovf(1'b0, "R1 overflow");

        // R2 writable bits
        wr(5'd1, 32'hffff_ffff); chk_reg(5'd1, 32'h1cfff, "R2 unc mask wmask");
        wr(5'd2, 32'hffff_ffff); chk_reg(5'd2, 32'h1cfff, "R2 unc sev wmask");
        wr(5'd4, 32'hffff_ff80); chk_reg(5'd4, 32'h0, "R2 cor mask wmask");
        wr(5'd5, 32'h0);         chk_reg(5'd5, 32'h200, "R2 cap read-only");
        wr(5'd1, 32'h0);         chk_reg(5'd1, 32'h0, "R2 unc mask clear");

        // R3/R4/R5 injection, pointer, header clipping
        inj_unc(5'd14, 5'd3, 32'hA000_0000, 1'b1, "R10 irq unmasked unc");
        chk_reg(5'd0, 32'h4000, "R3 status after inject");
        chk_reg(5'd5, 32'h20e, "R4 pointer internal");
        chk_reg(5'd16, 32'hA000_0000, "R4 hdr0");
        chk_reg(5'd18, 32'hA000_0002, "R5 hdr2 inside count");
        chk_reg(5'd19, 32'h0, "R5 hdr3 beyond count");
        inj_unc(5'd1, 5'd16, 32'hB000_0000, 1'b1, "R10 irq second");
        inj_unc(5'd16, 5'd1, 32'hC000_0000, 1'b1, "R10 irq third");
        chk_reg(5'd0, 32'h14002, "R3 union of three");
        chk_reg(5'd5, 32'h20e, "R4 pointer stays oldest");
        inj_unc(5'd12, 5'd1, 32'h0, 1'b0, "R3 kind12 no irq");
        inj_unc(5'd20, 5'd1, 32'h0, 1'b0, "R3 kind20 no irq");
        chk_reg(5'd0, 32'h14002, "R3 illegal kinds ignored");

        // R7 non-matching writes
        wr(5'd0, 32'h2);
        chk_reg(5'd0, 32'h14002, "R7 wrong bit status");
        chk_reg(5'd5, 32'h20e, "R7 wrong bit pointer");
        wr(5'd0, 32'h4002);
        chk_reg(5'd0, 32'h14002, "R7 multi bit status");
        chk_reg(5'd16, 32'hA000_0000, "R7 multi bit hdr");

        // R6 retire in order
        wr(5'd0, 32'h4000);
        chk_reg(5'd0, 32'h10002, "R6 status after pop1");
        chk_reg(5'd5, 32'h201, "R6 pointer after pop1");
        chk_reg(5'd31, 32'hB000_000F, "R6 hdr15 after pop1");
        wr(5'd0, 32'h2);
        chk_reg(5'd5, 32'h210, "R6 pointer after pop2");
        chk_reg(5'd16, 32'hC000_0000, "R6 hdr0 after pop2");
        chk_reg(5'd17, 32'h0, "R5 hdr1 clipped");
        wr(5'd0, 32'h10000);
        chk_reg(5'd0, 32'h0, "R6 status empty");
        chk_reg(5'd5, 32'h200, "R4 pointer empty");
        chk_reg(5'd16, 32'h0, "R4 hdr empty");

        // R10 masked injection
        wr(5'd1, 32'h1cfff);
        inj_unc(5'd5, 5'd1, 32'h0, 1'b0, "R10 masked no irq");
        chk_reg(5'd0, 32'h20, "R3 masked still logged");
        wr(5'd0, 32'h20);
        chk_reg(5'd0, 32'h0, "R6 masked entry retired");

        // R8 overflow
        for (int k = 0; k < 8; k++) inj_unc(5'(k), 5'd1, 32'(k), 1'b0, "R10 masked fill");
        chk_ovf(1'b0, "R8 no overflow at full");
        inj_unc(5'd8, 5'd1, 32'h0, 1'b0, "R10 dropped no irq");
        chk_ovf(1'b1, "R8 overflow set");
        chk_reg(5'd0, 32'hff, "R8 ninth dropped");
        wr(5'd0, 32'h1);
        chk_reg(5'd5, 32'h201, "R6 pointer after drain1");
        chk_reg(5'd16, 32'h1, "R6 hdr after drain1");
        for (int k = 1; k < 8; k++) wr(5'd0, 32'h1 << k);
        chk_reg(5'd0, 32'h0, "R8 drained");
        chk_ovf(1'b1, "R8 overflow sticky");

        // R9 correctable
        wr(5'd4, 32'h0);
        inj_cor(3'd6, 1'b0, 32'h0, 1'b1, "R10 cor irq");
        chk_reg(5'd3, 32'h40, "R9 cor set");
        inj_cor(3'd7, 1'b0, 32'h0, 1'b0, "R9 cor kind7 no irq");
        chk_reg(5'd3, 32'h40, "R9 cor kind7 ignored");
        wr(5'd3, 32'hffff_ffbf);
        chk_reg(5'd3, 32'h40, "R9 w1c other bits");
        wr(5'd3, 32'h40);
        chk_reg(5'd3, 32'h0, "R9 w1c cleared");
        inj_cor(3'd2, 1'b1, 32'h4, 1'b1, "R10 cor irq race");
        chk_reg(5'd3, 32'h4, "R9 set wins");
        wr(5'd4, 32'h7f);
        inj_cor(3'd0, 1'b0, 32'h0, 1'b0, "R10 cor masked no irq");
        chk_reg(5'd3, 32'h5, "R9 masked cor logged");

        @(negedge clk); go_idle();
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

endmodule